// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Sequencer

This block sits on the controller side of an asynchronous EDO DRAM. It turns a single synchronous request into the strobe sequence the memory needs. A request carries a row, a starting column, a read/write flag, a burst length and the first write word. The sequencer lowers RAS# with the row on the shared address bus. It then serves every beat of the burst as one CAS# low pulse on successive columns of that row, keeping RAS# low between the pulses. After the last beat it releases RAS# and waits out precharge before it accepts the next request.

Every strobe interval is a parameter counted in clock cycles: row-to-column delay, CAS# low width, CAS# high gap, minimum RAS# low time and precharge. Read words are captured a configurable number of cycles after each CAS# fall and are returned with a one-cycle valid pulse. During the CAS# high gap of a read burst, OE# follows one of two shapes, chosen by a parameter, so that the memory's output drivers stay off. The first shape is a short high pulse after a low start. The second is a high level held from the CAS# rise. A write keeps OE# high and WE# low for the whole row-open period. The write data bus is driven only while CAS# is low. The source supplies each following write word when the block asks for it.

Top module: `edo_page_seq`

## Requirements
- R1: An accepted request first drives the row on `addr` with `ras_n` low and `cas_n` high for exactly T_RCD cycles. It then lowers `cas_n` with the starting column on `addr`. `cas_n` is never low while `ras_n` is high.
- R2: Each beat holds `cas_n` low for exactly T_CAS cycles. Between beats, `cas_n` is high for exactly T_CP cycles while `ras_n` stays low. A request with `req_len` = n gives n+1 beats. Beat k uses column (start + k) modulo 2^COL_W.
- R3: `ras_n` stays low for at least T_RAS cycles per request and then stays high for exactly T_RP cycles before `req_ready` returns high.
- R4: With OE_MODE = 1, during each CAS# high gap of a read, `oe_n` is low in gap cycle 0, high in gap cycles 1 to T_OEP, and low in the remaining gap cycles.
- R5: With OE_MODE = 0, during each CAS# high gap of a read, `oe_n` is high in gap cycles 0 to T_OEHC-1 and low in the remaining gap cycles.
- R6: During a read, `oe_n` is low whenever `cas_n` is low. Outside an open row, `oe_n` and `we_n` are high.
- R7: For each read beat, `rd_data` takes the `dq_in` value present in CAS# low cycle RD_LAT-1. `rd_valid` is high for one cycle, which is CAS# low cycle RD_LAT of that beat (cycles counted from 0 at the CAS# fall). There is exactly one pulse per beat.
- R8: During a write, `we_n` is low from the RAS# fall until RAS# rises, so it is low before every CAS# fall. `oe_n` stays high. `dq_oe` equals NOT `cas_n`. `wr_take` is high in the last CAS# low cycle of each beat; in that cycle `wr_data` must carry the next word. `dq_out` holds the word of the current beat, and the first word is taken with the request.
- R9: `req_ready` is high only while the block is idle. In that state `ras_n`, `cas_n`, `oe_n` and `we_n` are high and `dq_oe` and `rd_valid` are low, and this is also the state after reset. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, request can be taken |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Starting column |
| req_len | input | LEN_W | Beats minus one |
| wr_data | input | DATA_W | Write word (first with request, next while wr_take) |
| wr_take | output | 1 | Current write beat finishing, next word wanted |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | One-cycle read word strobe |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_out | output | DATA_W | Write data toward memory |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | DATA_W | Data from memory |

## Verification
The bench sweeps every burst length against starting columns that include the top column, so a design that forgets to wrap, or that drops or adds a beat, returns read words from the wrong cells. It measures every strobe run at the pins: RAS# to CAS#, CAS# low, the CAS# gap, total RAS# low time when a single beat is shorter than T_RAS, and precharge. An off-by-one counter shows up as a wrong run length. It runs both OE# gap shapes side by side on two copies. A swapped or shifted OE# pulse would leave the memory drivers on during the CAS# high time. Read captures are checked against words the bench wrote itself, so a capture taken one cycle early or late shows up as a data mismatch or as a valid pulse in the wrong cycle.

// File: rtl/edo_page_seq.sv
module edo_page_seq #(
  parameter int ROW_W   = 4,
  parameter int COL_W   = 4,
  parameter int DATA_W  = 16,
  parameter int LEN_W   = 2,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  parameter int T_CP    = 3,
  parameter int T_RP    = 3,
  parameter int T_RAS   = 7,
  parameter int T_OEHC  = 2,
  parameter int T_OEP   = 1,
  parameter int RD_LAT  = 1,
  parameter int OE_MODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_take,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              ras_n,
  output logic              cas_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);
  localparam int AW   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TM0  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TM1  = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int TM2  = (TM0 > TM1) ? TM0 : TM1;
  localparam int TM3  = (T_OEP + 1 > T_OEHC) ? T_OEP + 1 : T_OEHC;
  localparam int TMAX = (TM2 > TM3) ? TM2 : TM3;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(T_RAS + 1);
  localparam logic [CW-1:0] C_RCD  = CW'(T_RCD - 1);
  localparam logic [CW-1:0] C_CAS  = CW'(T_CAS - 1);
  localparam logic [CW-1:0] C_CP   = CW'(T_CP - 1);
  localparam logic [CW-1:0] C_RP   = CW'(T_RP - 1);
  localparam logic [CW-1:0] C_RD   = CW'(RD_LAT - 1);
  localparam logic [CW-1:0] C_OEP  = CW'(T_OEP);
  localparam logic [CW-1:0] C_OEHC = CW'(T_OEHC);
  localparam logic [RW-1:0] R_LAST = RW'(T_RAS - 1);
  localparam logic [RW-1:0] R_SAT  = RW'(T_RAS);

  typedef enum logic [2:0] {S_IDLE, S_RCD, S_CASL, S_GAP, S_HOLD, S_PRE} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [RW-1:0]     ras_cnt;
  logic              wr;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic [LEN_W-1:0]  left;
  logic [DATA_W-1:0] wdat;
  logic              ras_done;
  logic              gap_pulse, gap_hold, gap_oe;

  assign ras_done  = ras_cnt >= R_LAST;
  assign req_ready = st == S_IDLE;
  assign ras_n     = st == S_IDLE || st == S_PRE;
  assign cas_n     = st != S_CASL;
  assign we_n      = !(wr && !ras_n);
  assign dq_oe     = wr && st == S_CASL;
  assign dq_out    = wdat;
  assign wr_take   = wr && st == S_CASL && cnt == C_CAS;
  assign gap_pulse = cnt >= CW'(1) && cnt <= C_OEP;
  assign gap_hold  = cnt < C_OEHC;
  assign gap_oe    = (OE_MODE == 1) ? gap_pulse : gap_hold;
  assign oe_n      = wr ? 1'b1 :
                     (st == S_CASL) ? 1'b0 :
                     (st == S_GAP)  ? gap_oe : 1'b1;
  assign addr      = (st == S_RCD) ? AW'(row) :
                     (st == S_CASL || st == S_GAP || st == S_HOLD) ? AW'(col) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || ras_n) ras_cnt <= '0;
    else if (ras_cnt != R_SAT) ras_cnt <= ras_cnt + RW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; wr <= 1'b0; row <= '0; col <= '0; left <= '0;
      wdat <= '0; rd_data <= '0; rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      cnt      <= cnt + CW'(1);
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (req_valid) begin
            wr <= req_write; row <= req_row; col <= req_col; left <= req_len;
            wdat <= wr_data; st <= S_RCD;
          end
        end
        S_RCD: if (cnt == C_RCD) begin st <= S_CASL; cnt <= '0; end
        S_CASL: begin
          if (!wr && cnt == C_RD) begin rd_data <= dq_in; rd_valid <= 1'b1; end
          if (cnt == C_CAS) begin
            cnt <= '0;
            if (wr) wdat <= wr_data;
            if (left == '0) st <= ras_done ? S_PRE : S_HOLD;
            else begin
              left <= left - LEN_W'(1);
              col  <= col + COL_W'(1);
              st   <= S_GAP;
            end
          end
        end
        S_GAP:  if (cnt == C_CP) begin st <= S_CASL; cnt <= '0; end
        S_HOLD: if (ras_done) begin st <= S_PRE; cnt <= '0; end
        S_PRE:  if (cnt == C_RP) begin st <= S_IDLE; cnt <= '0; wr <= 1'b0; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_cas_inside_ras_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  assert_ras_min_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $past(ras_cnt) >= R_LAST);
  assert_drive_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!cas_n && !we_n && oe_n));
  assert_we_before_cas_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> !$past(we_n));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ras_n && cas_n && oe_n && we_n && !dq_oe));
  assert_read_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && we_n) |-> !oe_n);
endmodule

// File: tb/tb_edo_page_seq.sv
`timescale 1ns/1ps
module tb_edo_page_seq;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 3, T_RP = 3, T_RAS = 7;
  localparam int T_OEHC = 2, T_OEP = 1, RD_LAT = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_row = '0, req_col = '0;
  logic [1:0]  req_len = '0;
  logic [15:0] wr_data = '0;
  logic        req_ready, wr_take, rd_valid, ras_n, cas_n, oe_n, we_n, dq_oe;
  logic [15:0] rd_data, dq_out, dq_in;
  logic [3:0]  addr;
  logic        h_ready, h_take, h_valid, h_ras, h_cas, h_oe, h_we, h_dqoe;
  logic [15:0] h_rd, h_dq;
  logic [3:0]  h_addr;

  edo_page_seq #(.OE_MODE(1)) dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_row, .req_col, .req_len,
    .wr_data, .wr_take, .rd_data, .rd_valid, .ras_n, .cas_n, .oe_n, .we_n,
    .addr, .dq_out, .dq_oe, .dq_in);
  edo_page_seq #(.OE_MODE(0)) dut_h (
    .clk, .rst_n, .req_valid, .req_ready(h_ready), .req_write, .req_row, .req_col,
    .req_len, .wr_data, .wr_take(h_take), .rd_data(h_rd), .rd_valid(h_valid),
    .ras_n(h_ras), .cas_n(h_cas), .oe_n(h_oe), .we_n(h_we), .addr(h_addr),
    .dq_out(h_dq), .dq_oe(h_dqoe), .dq_in);

  int n_chk = 0, n_bad = 0;
  logic [15:0] mem [256];
  logic [15:0] exp_mem [256];
  logic [15:0] exp_q [$];
  logic [3:0]  rowl, cur_row, cur_col;
  logic [1:0]  cur_len;
  logic        cur_write;
  int seq = 0;

  function automatic logic [15:0] init_val(int i);
    return 16'(i * 257) ^ 16'hC35A;
  endfunction
  function automatic logic [15:0] pat(int s);
    return 16'(s * 16'h01F3 + 16'h0711);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
    end
  endtask

  assign dq_in = (!cas_n && !oe_n && we_n) ? mem[{rowl, addr}] : 16'h0;

  int  ras_lo = 0, cas_lo = 0, gap = 0, pre = 0, nbeat = 0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_rdy = 1'b1;
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    end else begin
      if (req_ready) chk(ras_n && cas_n && oe_n && we_n && !dq_oe, "R9 idle pins", 0, 1);
      if (p_ras && !ras_n) begin
        chk(addr == cur_row, "R1 row address", addr, cur_row);
        chk(cas_n, "R1 cas high at ras fall", cas_n, 1);
        rowl = addr; ras_lo = 0; nbeat = 0;
      end
      if (!cas_n && p_cas) begin
        if (nbeat == 0) chk(ras_lo == T_RCD, "R1 ras-to-cas", ras_lo, T_RCD);
        else chk(gap == T_CP, "R2 cas gap", gap, T_CP);
        chk(addr == 4'(cur_col + nbeat), "R2 column", addr, 4'(cur_col + nbeat));
        if (cur_write) begin
          chk(!we_n && dq_oe && oe_n, "R8 write strobes at cas fall", we_n, 0);
          mem[{rowl, addr}] = dq_out;
        end
        nbeat++; cas_lo = 0;
      end
      if (cas_n && !p_cas) begin
        chk(cas_lo == T_CAS, "R2 cas low width", cas_lo, T_CAS);
        gap = 0;
      end
      if (!cur_write && !ras_n && cas_n && nbeat > 0 && nbeat <= int'(cur_len)) begin
        chk(oe_n == (gap >= 1 && gap <= T_OEP), "R4 oe pulse in gap", oe_n, gap >= 1 && gap <= T_OEP);
        chk(h_oe == (gap < T_OEHC), "R5 oe hold in gap", h_oe, gap < T_OEHC);
      end
      if (!cas_n && !cur_write) chk(!oe_n, "R6 oe during read cas", oe_n, 0);
      if (cur_write && !ras_n)
        chk(dq_oe == !cas_n && oe_n && !we_n, "R8 write drive window", dq_oe, !cas_n);
      if (!p_ras && ras_n) begin
        chk(ras_lo >= T_RAS, "R3 ras low min", ras_lo, T_RAS);
        chk(nbeat == int'(cur_len) + 1, "R2 beat count", nbeat, int'(cur_len) + 1);
        chk(oe_n && we_n, "R6 pins high after row", oe_n, 1);
        pre = 0;
      end
      if (req_ready && !p_rdy) chk(pre == T_RP, "R3 precharge", pre, T_RP);
      if (rd_valid) begin
        chk(exp_q.size() > 0, "R7 unexpected valid", exp_q.size(), 1);
        if (exp_q.size() > 0) begin
          chk(rd_data == exp_q[0], "R7 read data", rd_data, exp_q[0]);
          chk(h_rd == exp_q[0] && h_valid, "R7 read data hold-mode copy", h_rd, exp_q[0]);
          void'(exp_q.pop_front());
        end
        chk(!cas_n && cas_lo == RD_LAT, "R7 valid cycle", cas_lo, RD_LAT);
      end
      if (!ras_n) ras_lo++;
      if (!cas_n) cas_lo++;
      if (cas_n && !ras_n) gap++;
      if (ras_n && !req_ready) pre++;
      p_ras = ras_n; p_cas = cas_n; p_rdy = req_ready;
    end
  end

  task automatic access(bit w, logic [3:0] r, logic [3:0] c, logic [1:0] len);
    int beats = int'(len) + 1;
    int base = seq;
    int takes = 0;
    seq += beats;
    while (!req_ready) @(negedge clk);
    cur_write = w; cur_row = r; cur_col = c; cur_len = len;
    for (int i = 0; i < beats; i++) begin
      if (w) exp_mem[{r, 4'(c + i)}] = pat(base + i);
      else exp_q.push_back(exp_mem[{r, 4'(c + i)}]);
    end
    req_valid = 1'b1; req_write = w; req_row = r; req_col = c; req_len = len;
    wr_data = pat(base);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 ready drops after accept", req_ready, 0);
    while (!req_ready) begin
      if (w && wr_take) begin takes++; wr_data = pat(base + takes); end
      @(negedge clk);
    end
    chk(takes == (w ? beats : 0), "R8 write beats taken", takes, w ? beats : 0);
    chk(exp_q.size() == 0, "R7 read beats returned", exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    cur_write = 1'b0; cur_row = '0; cur_col = '0; cur_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && ras_n && cas_n && oe_n && we_n && !dq_oe && !rd_valid,
        "R9 reset state", req_ready, 1);
    access(1'b0, 4'd9, 4'd14, 2'd3);
    for (int len = 0; len < 4; len++) begin
      for (int k = 0; k < 4; k++) begin
        logic [3:0] c = (k == 0) ? 4'd0 : (k == 1) ? 4'd7 : (k == 2) ? 4'd13 : 4'd15;
        logic [3:0] r = 4'(len * 4 + k);
        access(1'b1, r, c, 2'(len));
        access(1'b0, r, c, 2'(len));
        access(1'b0, r, 4'(c + 1), 2'd3);
      end
    end
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule